// File: doc/BRIEF.md
# Eight-Channel Mailbox Transmit Side

This block is the sending half of an inter-processor mailbox. A host reaches it through a small 32-bit register port. To send, the host writes a 64-bit message as a low word and a high word, names one of eight target channels, and then writes a trigger. The message is stored in that channel's one-entry slot, which the remote processor reads directly. The remote side is modelled as one fetch strobe per channel.

Each channel keeps three flags, all visible in one status word:
- **Delivered** is set when the channel accepts a message.
- **Busy** is set while the message waits for the remote fetch.
- **Overflow** is set when a trigger is dropped because the slot is still occupied.

A send is complete when the channel shows delivered set and busy clear. The delivered and overflow flags are cleared by writing a bit mask to a clear register.

Three event sources feed one interrupt line: message accepted, message dropped, and busy released by a fetch. Each source can be masked. Pending events are sticky until the host clears them.

Top module: `mbx_inbox`

## Requirements
- R1: After synchronous reset the status word reads 0, the IRQ mask reads 7 (all sources masked), pending reads 0, `irq` is low, and the id, low and high latches read 0.
- R2: Writes to offset 0x4 (low word), 0x8 (high word) and 0x0 (channel id) are latched and read back at the same offsets. The id keeps only bits [2:0].
- R3: Writing offset 0xC with bit 0 set, to an idle channel, does three things at the next clock edge:
  - stores {high, low} in that channel's slot (`rmt_msg` bits [64*c+63:64*c], high word on top);
  - sets that channel's busy bit;
  - sets that channel's delivered bit.
  A write to 0xC with bit 0 clear has no effect.
- R4: A fetch strobe on a busy channel clears its busy bit at the next edge and leaves its delivered and overflow bits alone. A fetch on an idle channel has no effect.
- R5: A trigger on a channel whose busy bit is set drops the message. It sets that channel's overflow bit and leaves the slot unchanged. This also holds when a fetch of that channel arrives in the same cycle; that fetch still clears busy.
- R6: Writing offset 0x10 clears every delivered bit selected by data bits [23:16] and every overflow bit selected by data bits [15:8]. Busy bits are unaffected.
- R7: The status word at offset 0x14 has delivered bits in [23:16], overflow bits in [15:8], busy bits in [7:0] (bit index = channel) and zeros above bit 23.
- R8: Three event sources exist: bit 0 is busy released by a fetch, bit 1 is a dropped trigger, bit 2 is an accepted trigger. An event sets its pending bit only when the same bit of the mask at offset 0x1C is clear. Pending bits read at offset 0x18 in [2:0], and `irq` is the OR of the pending bits.
- R9: Writing offset 0x18 with bit 0 set clears all pending bits. An event in the same cycle still sets its bit. A write with bit 0 clear leaves pending unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rmt_fetch | input | 8 | Remote fetch strobe, one per channel |
| rmt_busy | output | 8 | Per-channel slot occupied |
| rmt_msg | output | 512 | Per-channel 64-bit slot contents, channel c at [64c+63:64c] |
| irq | output | 1 | Interrupt, OR of pending sources |

## Verification
The hardest situations to reach are those where two things coincide in one clock cycle:
- a trigger to a channel arrives in the same cycle as that channel's fetch;
- a pending clear arrives in the same cycle as a new event.

The bench holds a fetch strobe across the same clock edge as the trigger or clear register write, so both land on one edge. It also sweeps all eight mask values. Under each mask it runs an accept, a drop and a release on one channel, so each interrupt source is isolated under every masking combination.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int CH_COUNT  = 8;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int ID_W      = $clog2(CH_COUNT);
    localparam int SRC_COUNT = 3;

    localparam logic [ADDR_W-1:0] OFS_ID    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LO    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_HI    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h1C;

    // event source bit positions
    localparam int SRC_REL = 0;
    localparam int SRC_OVF = 1;
    localparam int SRC_DLV = 2;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } msg_t;

    localparam int MSG_W = $bits(msg_t);

    typedef struct packed {
        logic [CH_COUNT-1:0] dlv;
        logic [CH_COUNT-1:0] ovf;
        logic [CH_COUNT-1:0] busy;
    } flags_t;

    function automatic logic [WORD_W-1:0] status_word(flags_t f);
        return {{(WORD_W - 3*CH_COUNT){1'b0}}, f};
    endfunction
endpackage

// File: rtl/mbx_regif.sv
module mbx_regif
    import mbx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output msg_t                 msg_lat,
    output logic [ID_W-1:0]      id_lat,
    output logic [SRC_COUNT-1:0] mask,
    output logic                 trig,
    output logic [CH_COUNT-1:0]  clr_dlv,
    output logic [CH_COUNT-1:0]  clr_ovf,
    output logic                 pend_clr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_lat <= '0;
            id_lat  <= '0;
            mask    <= '1;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_LO:   msg_lat.lo <= reg_wdata;
                OFS_HI:   msg_lat.hi <= reg_wdata;
                OFS_ID:   id_lat     <= reg_wdata[ID_W-1:0];
                OFS_MASK: mask       <= reg_wdata[SRC_COUNT-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        trig     = reg_wr && (reg_addr == OFS_TRIG) && reg_wdata[0];
        pend_clr = reg_wr && (reg_addr == OFS_PEND) && reg_wdata[0];
        clr_dlv  = '0;
        clr_ovf  = '0;
        if (reg_wr && reg_addr == OFS_CLR) begin
            clr_dlv = reg_wdata[2*CH_COUNT +: CH_COUNT];
            clr_ovf = reg_wdata[CH_COUNT +: CH_COUNT];
        end
    end
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_hit,
    input  msg_t msg_in,
    input  logic fetch,
    input  logic clr_dlv,
    input  logic clr_ovf,
    output logic busy,
    output logic dlv,
    output logic ovf,
    output msg_t slot,
    output logic ev_accept,
    output logic ev_drop,
    output logic ev_release
);
    always_comb begin
        ev_accept  = trig_hit && !busy;
        ev_drop    = trig_hit && busy;
        ev_release = fetch && busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            dlv  <= 1'b0;
            ovf  <= 1'b0;
            slot <= '0;
        end else begin
            if (ev_accept)       busy <= 1'b1;
            else if (ev_release) busy <= 1'b0;
            if (ev_accept)       dlv  <= 1'b1;
            else if (clr_dlv)    dlv  <= 1'b0;
            if (ev_drop)         ovf  <= 1'b1;
            else if (clr_ovf)    ovf  <= 1'b0;
            if (ev_accept)       slot <= msg_in;
        end
    end

    a_r4_busy_falls_on_fetch: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(fetch));
    a_r5_drop_keeps_slot: assert property (@(posedge clk) disable iff (rst)
        ev_drop |=> ($stable(slot) && ovf));
    a_r3_accept_marks: assert property (@(posedge clk) disable iff (rst)
        ev_accept |=> (busy && dlv));
    a_r6_clear_spares_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !fetch) |=> busy);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_COUNT-1:0] ev,
    input  logic [SRC_COUNT-1:0] mask,
    input  logic                 pend_clr,
    output logic [SRC_COUNT-1:0] pend,
    output logic                 irq
);
    logic [SRC_COUNT-1:0] kept;

    always_comb begin
        kept = pend_clr ? '0 : pend;
        irq  = |pend;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= kept | (ev & ~mask);
    end

    for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
        a_r8_pend_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
            $rose(pend[s]) |-> $past(ev[s] && !mask[s]));
    end

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !pend_clr) |=> irq);
endmodule

// File: rtl/mbx_inbox.sv
module mbx_inbox
    import mbx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [WORD_W-1:0]          reg_wdata,
    output logic [WORD_W-1:0]          reg_rdata,
    input  logic [CH_COUNT-1:0]        rmt_fetch,
    output logic [CH_COUNT-1:0]        rmt_busy,
    output logic [CH_COUNT*MSG_W-1:0]  rmt_msg,
    output logic                       irq
);
    msg_t                 msg_lat;
    logic [ID_W-1:0]      id_lat;
    logic [SRC_COUNT-1:0] mask;
    logic                 trig;
    logic [CH_COUNT-1:0]  clr_dlv, clr_ovf;
    logic                 pend_clr;
    logic [SRC_COUNT-1:0] pend;
    flags_t               flags;
    logic [CH_COUNT-1:0]  acc_v, drop_v, rel_v;
    logic [SRC_COUNT-1:0] ev;

    mbx_regif u_regif (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .msg_lat(msg_lat), .id_lat(id_lat),
        .mask(mask), .trig(trig), .clr_dlv(clr_dlv), .clr_ovf(clr_ovf),
        .pend_clr(pend_clr)
    );

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        msg_t slot_c;
        mbx_chan u_chan (
            .clk(clk), .rst(rst),
            .trig_hit(trig && (id_lat == ID_W'(c))),
            .msg_in(msg_lat), .fetch(rmt_fetch[c]),
            .clr_dlv(clr_dlv[c]), .clr_ovf(clr_ovf[c]),
            .busy(flags.busy[c]), .dlv(flags.dlv[c]), .ovf(flags.ovf[c]),
            .slot(slot_c), .ev_accept(acc_v[c]), .ev_drop(drop_v[c]),
            .ev_release(rel_v[c])
        );
        assign rmt_msg[c*MSG_W +: MSG_W] = slot_c;
    end

    always_comb begin
        ev          = '0;
        ev[SRC_REL] = |rel_v;
        ev[SRC_OVF] = |drop_v;
        ev[SRC_DLV] = |acc_v;
        rmt_busy    = flags.busy;
    end

    mbx_irq u_irq (
        .clk(clk), .rst(rst), .ev(ev), .mask(mask), .pend_clr(pend_clr),
        .pend(pend), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ID:   reg_rdata = WORD_W'(id_lat);
            OFS_LO:   reg_rdata = msg_lat.lo;
            OFS_HI:   reg_rdata = msg_lat.hi;
            OFS_STAT: reg_rdata = status_word(flags);
            OFS_PEND: reg_rdata = WORD_W'(pend);
            OFS_MASK: reg_rdata = WORD_W'(mask);
            default:  reg_rdata = '0;
        endcase
    end

    a_r3_single_accept: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_v | drop_v));
endmodule

// File: tb/mbx_inbox_test.sv
module mbx_inbox_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [7:0]   rmt_fetch = '0;
    logic [7:0]   rmt_busy;
    logic [511:0] rmt_msg;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_msg [8];
    logic [7:0]  e_busy, e_dlv, e_ovf;

    mbx_inbox uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rmt_fetch(rmt_fetch),
        .rmt_busy(rmt_busy), .rmt_msg(rmt_msg), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [7:0] f = 8'h00);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; rmt_fetch = f;
        @(negedge clk);
        reg_wr = 1'b0; rmt_fetch = '0;
    endtask

    task automatic fetch(int c);
        @(negedge clk);
        rmt_fetch = 8'(1 << c);
        @(negedge clk);
        rmt_fetch = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] stat_exp();
        return {8'h00, e_dlv, e_ovf, e_busy};
    endfunction

    task automatic send(int c, logic [63:0] m);
        wr(8'h04, m[31:0]);
        wr(8'h08, m[63:32]);
        wr(8'h00, 32'(c));
        wr(8'h0C, 32'h1);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        e_busy = '0; e_dlv = '0; e_ovf = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h14, d); check("R1 status", d, 0);
        rd(8'h1C, d); check("R1 mask", d, 7);
        rd(8'h18, d); check("R1 pend", d, 0);
        check("R1 irq", irq, 0);
        rd(8'h00, d); check("R1 id", d, 0);
        rd(8'h04, d); check("R1 lo", d, 0);
        rd(8'h08, d); check("R1 hi", d, 0);

        // R2 latches
        wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); check("R2 lo", d, 32'hA5A5_0F0F);
        wr(8'h08, 32'h1234_5678); rd(8'h08, d); check("R2 hi", d, 32'h1234_5678);
        wr(8'h00, 32'hFF);        rd(8'h00, d); check("R2 id masked", d, 7);

        // R3 trigger with bit 0 clear does nothing
        wr(8'h00, 0);
        wr(8'h0C, 32'h2);
        rd(8'h14, d); check("R3 no-trigger status", d, 0);
        check("R3 no-trigger slot", rmt_msg[63:0], 0);

        wr(8'h1C, 0);
        wr(8'h18, 1);

        // R3/R5/R7 sweep every channel
        for (int c = 0; c < 8; c++) begin
            logic [63:0] m;
            m = {32'hC0DE_0000 + 32'(c * 17), 32'h0BAD_0000 ^ 32'(c * 257)};
            send(c, m);
            exp_msg[c] = m;
            e_busy[c] = 1'b1; e_dlv[c] = 1'b1;
            check("R3 slot", rmt_msg[c*64 +: 64], m);
            check("R3 busy", rmt_busy, e_busy);
            rd(8'h14, d); check("R7 status after accept", d, stat_exp());
            send(c, ~m);
            e_ovf[c] = 1'b1;
            check("R5 slot kept", rmt_msg[c*64 +: 64], exp_msg[c]);
            rd(8'h14, d); check("R5 overflow", d, stat_exp());
        end

        // R4 fetch sweep
        for (int c = 0; c < 8; c++) begin
            fetch(c);
            e_busy[c] = 1'b0;
            rd(8'h14, d); check("R4 fetch clears busy", d, stat_exp());
            fetch(c);
            rd(8'h14, d); check("R4 idle fetch", d, stat_exp());
        end

        // R6 selective clear
        wr(8'h10, {8'h00, 8'h0F, 8'hF0, 8'hFF});
        e_dlv = 8'hF0; e_ovf = 8'h0F;
        rd(8'h14, d); check("R6 partial clear", d, stat_exp());
        send(0, 64'h1111_2222_3333_4444);
        e_busy[0] = 1'b1; e_dlv[0] = 1'b1;
        wr(8'h10, 32'h00FF_FF00);
        e_dlv = '0; e_ovf = '0;
        rd(8'h14, d); check("R6 busy untouched", d, stat_exp());

        // R5 trigger while fetch in same cycle
        send(3, 64'hAAAA_BBBB_CCCC_DDDD);
        wr(8'h0C, 1, 8'h08);
        check("R5 same-cycle slot", rmt_msg[3*64 +: 64], 64'hAAAA_BBBB_CCCC_DDDD);
        rd(8'h14, d); check("R5 same-cycle status", d, {8'h00, 8'h08, 8'h08, 8'h01});
        wr(8'h10, 32'h00FF_FF00);

        // R8 mask sweep on channel 1
        for (int m = 0; m < 8; m++) begin
            wr(8'h1C, 32'(m));
            wr(8'h18, 1);
            rd(8'h18, d); check("R9 cleared", d, 0);
            check("R8 irq low", irq, 0);
            send(1, 64'(m));
            send(1, 64'hFFFF);
            fetch(1);
            rd(8'h18, d); check("R8 pend", d, 32'(~m & 7));
            check("R8 irq", irq, (m != 7));
            rd(8'h1C, d); check("R8 mask readback", d, 32'(m));
        end

        // R9 clear racing an event
        wr(8'h1C, 0);
        wr(8'h18, 1);
        send(2, 64'h55);
        rd(8'h18, d); check("R9 accept pend", d, 4);
        wr(8'h18, 0);
        rd(8'h18, d); check("R9 bit0 clear ignored", d, 4);
        wr(8'h18, 1, 8'h04);
        rd(8'h18, d); check("R9 event beats clear", d, 1);
        check("R9 irq", irq, 1);
        wr(8'h18, 1);
        rd(8'h18, d); check("R9 final clear", d, 0);
        check("R9 irq low", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule